// File: doc/BRIEF.md
# Drive Ready and Attention Status Keeper

This block holds the status bits that a host controller reads from a disc drive. Its main input is an active-low access-ready line from the head-positioning logic. While access-ready is inactive the drive is busy, and new seek, recalibrate and write commands are held off. When access-ready becomes active the drive stops being busy and raises attention, so the controller knows that the last positioning operation has finished.

A separate retract attention flag records head-retract events. The controller can clear the attention status through a clear-status strobe that carries control-bus bits. A watchdog timer of the same type as a 120 ms positioning timeout starts when a seek or recalibrate command is accepted. It counts slow timer ticks. If access-ready does not return before the timer runs out, a fault flag is raised. The access-ready line is asynchronous and passes through a configurable synchroniser before the block uses it.

Top module: `drv_status_ctl`

## Requirements
- R1: Status bit 0 (busy) reads 1 while `acc_rdy_n` is high and 0 while it is low. It follows the input SYNC_STAGES+1 clock edges after the input changes.
- R2: `cmd_en_o` is 1 exactly when busy is 0. A `cmd_start` pulse while `cmd_en_o` is 0 is ignored: it neither starts the timer nor clears an existing timeout fault.
- R3: When access-ready goes inactive, both the ready-attention flag and the retract attention flag clear, unless a retract event arrives in the same cycle.
- R4: When access-ready becomes active, the ready-attention flag sets, and status bit 7 (attention) reads 1.
- R5: A `clr_stb` pulse with `clr_bits[0]` = 1 clears both attention flags. With `clr_bits[0]` = 0 it changes nothing, whatever the other control bits hold.
- R6: A `retract_evt` pulse sets the retract flag (`retract_attn_o`). Status bit 7 is the OR of the two flags. A set wins over a clear in the same cycle.
- R7: An accepted `cmd_start` clears `tmo_fault_o` and arms the timer. If access-ready has not become active by then, `tmo_fault_o` rises on the TMO_TICKS-th `tick` after acceptance (120 by default).
- R8: Access-ready becoming active cancels an armed timer, so later ticks never raise the fault.
- R9: Reset gives status byte 0x01 (busy only), no attention, no retract flag, no fault and `cmd_en_o` = 0.
- R10: If access-ready becomes active in the same cycle as a clear-status strobe, the attention flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rdy_n | input | 1 | Access-ready, active low, asynchronous |
| retract_evt | input | 1 | One-cycle pulse: heads retracted |
| clr_stb | input | 1 | One-cycle clear-status strobe |
| clr_bits | input | CTRL_W | Control-bus bits sampled with `clr_stb` |
| cmd_start | input | 1 | One-cycle pulse: seek or recalibrate decoded |
| tick | input | 1 | One-cycle timer tick (1 kHz nominal) |
| stat_o | output | STAT_W | Status byte: bit 0 busy, bit 7 attention, others 0 |
| retract_attn_o | output | 1 | Retract attention flag |
| cmd_en_o | output | 1 | New seek, recalibrate and write allowed |
| tmo_fault_o | output | 1 | Positioning timeout fault |

## Verification
The bench goes after the races where two events hit the flags in one cycle:
- A retract arriving together with a clear or with ready going inactive. A design with the wrong priority drops the retract flag.
- Ready becoming active together with a clear strobe. A wrong design loses the completion attention.

It counts ticks to the exact edge of expiry. An off-by-one timer raises the fault one tick early or one tick late. It also checks:
- a cancelled timer stays silent through a long run of ticks;
- a command while busy leaves a standing fault in place;
- a clear strobe whose bit 0 is zero leaves attention set even with every other control bit set.

// File: rtl/drv_status_pkg.sv
package drv_status_pkg;

   typedef enum logic [0:0] {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_t;

   typedef struct packed {
      logic rdy_attn;
      logic ret_attn;
   } attn_flags_t;

endpackage

// File: rtl/dsc_rdy_sync.sv
module dsc_rdy_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_rdy_n,
   output logic rdy_q,
   output logic rdy_rise,
   output logic rdy_fall
);

   logic rdy_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rdy_s = ~acc_rdy_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], acc_rdy_n};
         end
         assign rdy_s = ~chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_q <= 1'b0;
      else        rdy_q <= rdy_s;
   end

   assign rdy_rise = rdy_s & ~rdy_q;
   assign rdy_fall = ~rdy_s & rdy_q;

endmodule

// File: rtl/dsc_attn_flags.sv
module dsc_attn_flags
   import drv_status_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rdy_rise,
   input  logic        rdy_fall,
   input  logic        retract_evt,
   input  logic        clr_req,
   output attn_flags_t flags
);

   attn_flags_t nxt;

   always_comb begin
      nxt = flags;
      // clears first, sets override (R6, R10)
      if (rdy_fall || clr_req) begin
         nxt.rdy_attn = 1'b0;
         nxt.ret_attn = 1'b0;
      end
      if (rdy_rise)    nxt.rdy_attn = 1'b1;
      if (retract_evt) nxt.ret_attn = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= nxt;
   end

endmodule

// File: rtl/dsc_cmd_timer.sv
module dsc_cmd_timer
   import drv_status_pkg::*;
#(
   parameter int TMO_TICKS = 120,
   localparam int CNT_W = (TMO_TICKS > 2) ? $clog2(TMO_TICKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic cancel,
   input  logic tick,
   output logic fault
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_TICKS - 1);

   tmr_state_t       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TMR_IDLE;
         cnt   <= '0;
         fault <= 1'b0;
      end else if (accept) begin
         state <= TMR_RUN;
         cnt   <= '0;
         fault <= 1'b0;
      end else if (cancel) begin
         state <= TMR_IDLE;
      end else if (state == TMR_RUN && tick) begin
         if (cnt == LAST) begin
            state <= TMR_IDLE;
            fault <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/drv_status_ctl.sv
module drv_status_ctl
   import drv_status_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int TMO_TICKS    = 120,
   parameter int STAT_W       = 8,
   parameter int BUSY_BIT     = 0,
   parameter int ATTN_BIT     = 7,
   parameter int CTRL_W       = 8,
   parameter int CLR_ATTN_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_rdy_n,
   input  logic              retract_evt,
   input  logic              clr_stb,
   input  logic [CTRL_W-1:0] clr_bits,
   input  logic              cmd_start,
   input  logic              tick,
   output logic [STAT_W-1:0] stat_o,
   output logic              retract_attn_o,
   output logic              cmd_en_o,
   output logic              tmo_fault_o
);

   generate
      if (TMO_TICKS < 2)            begin : g_bad_tmo  $error("TMO_TICKS must be at least 2"); end
      if (SYNC_STAGES < 0)          begin : g_bad_sync $error("SYNC_STAGES must not be negative"); end
      if (BUSY_BIT >= STAT_W)       begin : g_bad_busy $error("BUSY_BIT outside status word"); end
      if (ATTN_BIT >= STAT_W)       begin : g_bad_attn $error("ATTN_BIT outside status word"); end
      if (BUSY_BIT == ATTN_BIT)     begin : g_bad_same $error("BUSY_BIT and ATTN_BIT collide"); end
      if (CLR_ATTN_BIT >= CTRL_W)   begin : g_bad_clr  $error("CLR_ATTN_BIT outside control word"); end
   endgenerate

   logic        rdy_q, rdy_rise, rdy_fall;
   attn_flags_t flags;
   logic        unused_ctrl;

   assign unused_ctrl = ^clr_bits;

   dsc_rdy_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_rdy_n(acc_rdy_n),
      .rdy_q    (rdy_q),
      .rdy_rise (rdy_rise),
      .rdy_fall (rdy_fall)
   );

   dsc_attn_flags u_attn (
      .clk        (clk),
      .rst_n      (rst_n),
      .rdy_rise   (rdy_rise),
      .rdy_fall   (rdy_fall),
      .retract_evt(retract_evt),
      .clr_req    (clr_stb & clr_bits[CLR_ATTN_BIT]),
      .flags      (flags)
   );

   dsc_cmd_timer #(.TMO_TICKS(TMO_TICKS)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .accept(cmd_start & rdy_q),
      .cancel(rdy_rise),
      .tick  (tick),
      .fault (tmo_fault_o)
   );

   generate
      for (genvar i = 0; i < STAT_W; i++) begin : g_stat
         if (i == BUSY_BIT) begin : g_busy
            assign stat_o[i] = ~rdy_q;
         end else if (i == ATTN_BIT) begin : g_attn
            assign stat_o[i] = flags.rdy_attn | flags.ret_attn;
         end else begin : g_zero
            assign stat_o[i] = 1'b0;
         end
      end
   endgenerate

   assign retract_attn_o = flags.ret_attn;
   assign cmd_en_o       = rdy_q;

endmodule

// File: rtl/drv_status_chk.sv
module drv_status_chk #(
   parameter int STAT_W   = 8,
   parameter int BUSY_BIT = 0,
   parameter int ATTN_BIT = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retract_evt,
   input logic              clr_stb,
   input logic              clr_bit,
   input logic              cmd_start,
   input logic [STAT_W-1:0] stat_o,
   input logic              retract_attn_o,
   input logic              cmd_en_o,
   input logic              tmo_fault_o
);

   AST_BUSY_DROP_SETS_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_o[BUSY_BIT]) |-> stat_o[ATTN_BIT]); // R4

   AST_BUSY_RISE_CLEARS_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat_o[BUSY_BIT]) && !$past(retract_evt)) |-> (!stat_o[ATTN_BIT] && !retract_attn_o)); // R3

   AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && clr_bit && !retract_evt && !stat_o[BUSY_BIT]) |=> (!stat_o[ATTN_BIT] && !retract_attn_o)); // R5

   AST_RETRACT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      retract_evt |=> (retract_attn_o && stat_o[ATTN_BIT])); // R6

   AST_ACCEPT_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_en_o) |=> !tmo_fault_o); // R7

endmodule

bind drv_status_ctl drv_status_chk #(
   .STAT_W  (STAT_W),
   .BUSY_BIT(BUSY_BIT),
   .ATTN_BIT(ATTN_BIT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .retract_evt   (retract_evt),
   .clr_stb       (clr_stb),
   .clr_bit       (clr_bits[CLR_ATTN_BIT]),
   .cmd_start     (cmd_start),
   .stat_o        (stat_o),
   .retract_attn_o(retract_attn_o),
   .cmd_en_o      (cmd_en_o),
   .tmo_fault_o   (tmo_fault_o)
);

// File: tb/drv_status_ctl_bench.sv
module drv_status_ctl_bench;

   localparam int SYNC = 2;
   localparam int TMO  = 120;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_rdy_n = 1'b1;
   logic       retract_evt = 1'b0;
   logic       clr_stb = 1'b0;
   logic [7:0] clr_bits = 8'h00;
   logic       cmd_start = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] stat_o;
   logic       retract_attn_o, cmd_en_o, tmo_fault_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   drv_status_ctl #(.SYNC_STAGES(SYNC), .TMO_TICKS(TMO)) u_drv_status_ctl (
      .clk(clk), .rst_n(rst_n), .acc_rdy_n(acc_rdy_n), .retract_evt(retract_evt),
      .clr_stb(clr_stb), .clr_bits(clr_bits), .cmd_start(cmd_start), .tick(tick),
      .stat_o(stat_o), .retract_attn_o(retract_attn_o), .cmd_en_o(cmd_en_o),
      .tmo_fault_o(tmo_fault_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // [6] acc_rdy_n, [5] retract, [4] clr_stb, [3] clr bit0, [2] busy, [1] attn, [0] retract flag
   localparam logic [6:0] VEC [10] = '{
      7'b0_0_0_0_0_1_0,   // R4 ready active sets attention
      7'b0_0_1_0_0_1_0,   // R5 clear with bit0=0 ignored
      7'b0_0_1_1_0_0_0,   // R5 clear with bit0=1
      7'b0_1_0_0_0_1_1,   // R6 retract sets flag
      7'b1_0_0_0_1_0_0,   // R3 ready inactive clears both
      7'b1_1_0_0_1_1_1,   // R6 retract while busy
      7'b1_0_1_1_1_0_0,   // R5 clear both
      7'b1_1_1_1_1_1_1,   // R6 retract wins over clear
      7'b0_0_0_0_0_1_1,   // R4 ready again, retract kept
      7'b0_0_1_1_0_0_0    // R5 clear both
   };

   task automatic pulse_tick();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic settle();
      repeat (SYNC + 1) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R9", "reset status", int'(stat_o), 8'h01);
      chk("R9", "reset retract", int'(retract_attn_o), 0);
      chk("R9", "reset fault", int'(tmo_fault_o), 0);
      chk("R2", "reset cmd_en", int'(cmd_en_o), 0);
      rst_n = 1'b1;
      settle();
      chk("R1", "busy held", int'(stat_o[0]), 1);

      foreach (VEC[i]) begin
         @(negedge clk);
         acc_rdy_n   = VEC[i][6];
         retract_evt = VEC[i][5];
         clr_stb     = VEC[i][4];
         clr_bits    = VEC[i][3] ? 8'hFF : 8'hFE;
         @(negedge clk);
         retract_evt = 1'b0;
         clr_stb     = 1'b0;
         repeat (SYNC) @(negedge clk);
         chk($sformatf("R1 vec%0d", i), "busy", int'(stat_o[0]), int'(VEC[i][2]));
         chk($sformatf("R2 vec%0d", i), "cmd_en", int'(cmd_en_o), int'(!VEC[i][2]));
         chk($sformatf("R4 vec%0d", i), "attn", int'(stat_o[7]), int'(VEC[i][1]));
         chk($sformatf("R6 vec%0d", i), "retract", int'(retract_attn_o), int'(VEC[i][0]));
      end

      // R7: accepted command then timeout
      @(negedge clk) cmd_start = 1'b1;
      @(negedge clk) cmd_start = 1'b0;
      acc_rdy_n = 1'b1;
      settle();
      for (int t = 0; t < TMO - 1; t++) pulse_tick();
      chk("R7", "fault before last tick", int'(tmo_fault_o), 0);
      pulse_tick();
      chk("R7", "fault on last tick", int'(tmo_fault_o), 1);

      // R2: command while busy ignored
      @(negedge clk) cmd_start = 1'b1;
      @(negedge clk) cmd_start = 1'b0;
      chk("R2", "fault kept by ignored cmd", int'(tmo_fault_o), 1);

      // R8: cancel by ready
      acc_rdy_n = 1'b0;
      settle();
      @(negedge clk) cmd_start = 1'b1;
      @(negedge clk) cmd_start = 1'b0;
      chk("R7", "accept clears fault", int'(tmo_fault_o), 0);
      acc_rdy_n = 1'b1;
      settle();
      for (int t = 0; t < 50; t++) pulse_tick();
      acc_rdy_n = 1'b0;
      settle();
      for (int t = 0; t < 2 * TMO; t++) pulse_tick();
      chk("R8", "cancelled timer silent", int'(tmo_fault_o), 0);

      // R10: ready rise coincides with clear strobe
      @(negedge clk) acc_rdy_n = 1'b1;
      settle();
      chk("R3", "attn cleared on busy", int'(stat_o[7]), 0);
      @(negedge clk) acc_rdy_n = 1'b0;
      repeat (SYNC - 1) @(negedge clk);
      @(negedge clk) begin clr_stb = 1'b1; clr_bits = 8'hFF; end
      @(negedge clk) clr_stb = 1'b0;
      chk("R10", "rise beats clear", int'(stat_o[7]), 1);
      chk("R1", "busy low", int'(stat_o[0]), 0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule